// File: doc/BRIEF.md
# Extended Instruction Block Cache

This block is a small instruction-supply cache that keeps recently retired code as extended blocks. An extended block is a run of instructions that leaves through one exit, a conditional or an indirect branch. Unconditional direct jumps are absorbed into the run. Each cache entry is filed under the address of its exit branch. Its instructions are kept back to front: slot 0 holds the exit and higher slots hold earlier code. A fetch that lands on any recorded instruction of a block therefore finds it. A longer run that reaches the same exit later simply grows the entry at its head.

A fill port takes the retired stream one instruction per cycle through a valid/ready handshake. Each instruction carries its pointer, its instruction word and a two-bit kind. A lookup port takes a fetch pointer. One cycle later it answers with a hit flag, a length, and the instructions from that pointer through the exit in program order.

Top module: `xblk_cache`

## Requirements
- R1: After synchronous active-high reset, every entry is invalid, `fill_ready` is 1, `lk_hit` is 0 and `lk_len` is 0, and any lookup misses until a block has been written.
- R2: `fill_kind` is encoded as 0 = ordinary, 1 = unconditional direct jump, 2 = conditional branch, 3 = indirect branch. Only kinds 2 and 3 close a block. Instructions of kind 0 and 1 stay in the block under construction.
- R3: In the cycle after the edge that accepts a closing instruction, `fill_ready` is 0 and a lookup sees the old contents. From the next cycle on, `fill_ready` is 1 and the new block is visible.
- R4: An entry lives in set `end_ip[2 +: log2(SETS)]` and is tagged with its full exit pointer. Slot 0 holds the exit, and slot k holds the instruction k places before it.
- R5: A lookup presented at an edge is answered after that edge. `lk_len` gives the number of instructions from the fetch pointer through the exit. Position j of `lk_insns` (bits `j*32 +: 32`) holds the j-th of those instructions, and positions at or beyond `lk_len` read 0.
- R6: A fetch pointer equal to any recorded instruction of a resident entry hits, including interior instructions and the exit itself.
- R7: When a new block has the same exit pointer as a resident entry, no further way is taken. If the new block is longer, it replaces that entry in place. If it is not longer, the entry is unchanged.
- R8: A block holds at most 8 slots. When a run exceeds 8 instructions, its earliest instructions are dropped, and fetches to them miss.
- R9: A new entry goes to the lowest invalid way of its set, or else to the least recently used way. A commit makes its way most recent, and so does a lookup hit. A lookup hit in a cycle in which a commit is written does not change recency.
- R10: In the cycle after an edge with no lookup request, `lk_hit` is 0 and `lk_len` is 0.
- R11: If the fetch pointer is recorded in several entries, the entry with the lowest set and then the lowest way wins. Within an entry, the highest matching slot wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | A retired instruction is offered |
| fill_ready | output | 1 | The offered instruction is taken at this edge |
| fill_ip | input | 32 | Pointer of the offered instruction |
| fill_insn | input | 32 | Instruction word |
| fill_kind | input | 2 | Instruction kind (encoding in R2) |
| lk_valid | input | 1 | Lookup request |
| lk_ip | input | 32 | Fetch pointer |
| lk_hit | output | 1 | The request of the previous edge hit |
| lk_len | output | 4 | Number of instructions returned |
| lk_insns | output | 256 | Returned instructions in program order, position j at bits j*32 |

## Verification
The assertions watch invariants that hold in every cycle:
- the recency ages of each set always form a permutation;
- no set holds two valid entries with the same exit pointer;
- every valid entry sits in the set its exit pointer selects;
- the fill port drops `fill_ready` for exactly one cycle after a closing instruction;
- an idle lookup cycle never reports a hit.

Some behaviour depends on whole instruction histories, and only the bench's scenarios can show it: which way is evicted after a mix of fills and hits, head extension versus keeping a longer resident entry, dropping the earliest slots of an overlong run, jump absorption, and priority among duplicate matches. The bench checks these against a behavioural model on every cycle.

// File: rtl/xbc_pkg.sv
package xbc_pkg;

    localparam int IP_W    = 32;
    localparam int INSN_W  = 32;
    localparam int SLOTS   = 8;
    localparam int WAYS    = 4;
    localparam int SETS    = 4;
    localparam int IDX_LSB = 2;

    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int SET_W  = $clog2(SETS);

    typedef logic [IP_W-1:0]   ip_t;
    typedef logic [INSN_W-1:0] insn_t;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_JUMP  = 2'd1,
        K_COND  = 2'd2,
        K_IND   = 2'd3
    } kind_e;

    // Reverse-ordered run: index 0 is the exit branch.
    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        ip_t  [SLOTS-1:0]   ips;
        insn_t [SLOTS-1:0]  insns;
    } blk_t;

    typedef struct packed {
        logic valid;
        ip_t  tag;
        blk_t blk;
    } line_t;

    function automatic logic [SET_W-1:0] set_of(ip_t ip);
        return ip[IDX_LSB +: SET_W];
    endfunction

    function automatic logic closes_block(kind_e k);
        return (k == K_COND) || (k == K_IND);
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] c);
        return (c == CNT_W'(SLOTS)) ? c : c + CNT_W'(1);
    endfunction

endpackage

// File: rtl/xbc_builder.sv
module xbc_builder
    import xbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fill_valid,
    input  ip_t   fill_ip,
    input  insn_t fill_insn,
    input  kind_e fill_kind,
    output logic  fill_ready,
    output logic  commit_valid,
    output blk_t  commit_blk,
    output ip_t   commit_tag
);

    blk_t acc_q;
    blk_t pend_q;
    blk_t grown;
    logic pend_v;
    logic accept;
    logic closing;

    assign fill_ready = !pend_v;
    assign accept     = fill_valid && !pend_v;
    assign closing    = accept && closes_block(fill_kind);

    // Newest instruction enters at slot 0; the oldest falls off the top.
    always_comb begin
        grown          = acc_q;
        grown.cnt      = sat_inc(acc_q.cnt);
        grown.ips[0]   = fill_ip;
        grown.insns[0] = fill_insn;
        for (int i = 1; i < SLOTS; i++) begin
            grown.ips[i]   = acc_q.ips[i-1];
            grown.insns[i] = acc_q.insns[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            pend_q <= '0;
            pend_v <= 1'b0;
        end else begin
            pend_v <= closing;
            if (accept) begin
                if (closes_block(fill_kind)) begin
                    pend_q    <= grown;
                    acc_q.cnt <= '0;
                end else begin
                    acc_q <= grown;
                end
            end
        end
    end

    assign commit_valid = pend_v;
    assign commit_blk   = pend_q;
    assign commit_tag   = pend_q.ips[0];

    a_r3_bubble_after_close: assert property (@(posedge clk) disable iff (rst)
        closing |=> !fill_ready);

    a_r3_single_bubble: assert property (@(posedge clk) disable iff (rst)
        !fill_ready |=> fill_ready);

    a_r8_run_bounded: assert property (@(posedge clk) disable iff (rst)
        acc_q.cnt <= CNT_W'(SLOTS));

    a_r2_commit_nonempty: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> (commit_blk.cnt != '0));

endmodule

// File: rtl/xbc_lru.sv
module xbc_lru
    import xbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [WAYS-1:0]  valid_ways,
    output logic [WAY_W-1:0] victim
);

    // Age 0 is most recent, WAYS-1 least recent.
    logic [WAY_W-1:0] age [WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WAYS; w++) age[w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age[w] <= '0;
                else if (age[w] < age[touch_way])
                    age[w] <= age[w] + WAY_W'(1);
            end
        end
    end

    always_comb begin
        logic got;
        got    = 1'b0;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!got && !valid_ways[w]) begin
                got    = 1'b1;
                victim = WAY_W'(w);
            end
        end
        if (!got) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age[w] == WAY_W'(WAYS-1)) victim = WAY_W'(w);
            end
        end
    end

    for (genvar v = 0; v < WAYS; v++) begin : g_perm
        logic [WAYS-1:0] holders;
        always_comb begin
            for (int w = 0; w < WAYS; w++) holders[w] = (age[w] == WAY_W'(v));
        end
        a_r9_age_perm: assert property (@(posedge clk) disable iff (rst)
            $countones(holders) == 1);
    end

    a_r9_touch_mru: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> (age[$past(touch_way)] == '0));

endmodule

// File: rtl/xbc_store.sv
module xbc_store
    import xbc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                commit_valid,
    input  blk_t                commit_blk,
    input  ip_t                 commit_tag,
    input  logic                lk_valid,
    input  ip_t                 lk_ip,
    output logic                rsp_hit,
    output logic [CNT_W-1:0]    rsp_len,
    output insn_t [SLOTS-1:0]   rsp_insns
);

    line_t lines [SETS][WAYS];

    // ---------------- commit side ----------------
    logic [SET_W-1:0] cs;
    logic [WAYS-1:0]  same;
    logic             has_same;
    logic [WAY_W-1:0] sway;
    logic [WAY_W-1:0] vict [SETS];
    logic [WAY_W-1:0] target;
    logic             do_write;

    assign cs = set_of(commit_tag);

    always_comb begin
        has_same = 1'b0;
        sway     = '0;
        for (int w = 0; w < WAYS; w++) begin
            same[w] = lines[cs][w].valid && (lines[cs][w].tag == commit_tag);
            if (same[w] && !has_same) begin
                has_same = 1'b1;
                sway     = WAY_W'(w);
            end
        end
    end

    assign target   = has_same ? sway : vict[cs];
    assign do_write = commit_valid &&
                      (!has_same || (commit_blk.cnt > lines[cs][sway].blk.cnt));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    lines[s][w] <= '0;
        end else if (do_write) begin
            lines[cs][target].valid <= 1'b1;
            lines[cs][target].tag   <= commit_tag;
            lines[cs][target].blk   <= commit_blk;
        end
    end

    // ---------------- lookup side ----------------
    logic             found;
    logic [SET_W-1:0] fs;
    logic [WAY_W-1:0] fw;
    logic [SLOT_W-1:0] fm;
    line_t            sel;
    insn_t [SLOTS-1:0] nxt_insns;

    always_comb begin
        found = 1'b0;
        fs    = '0;
        fw    = '0;
        fm    = '0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int k = SLOTS-1; k >= 0; k--) begin
                    if (!found && lines[s][w].valid &&
                        (CNT_W'(k) < lines[s][w].blk.cnt) &&
                        (lines[s][w].blk.ips[k] == lk_ip)) begin
                        found = 1'b1;
                        fs    = SET_W'(s);
                        fw    = WAY_W'(w);
                        fm    = SLOT_W'(k);
                    end
                end
            end
        end
    end

    assign sel = lines[fs][fw];

    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            if (SLOT_W'(j) <= fm)
                nxt_insns[j] = sel.blk.insns[fm - SLOT_W'(j)];
            else
                nxt_insns[j] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_hit   <= 1'b0;
            rsp_len   <= '0;
            rsp_insns <= '0;
        end else if (lk_valid && found) begin
            rsp_hit   <= 1'b1;
            rsp_len   <= CNT_W'(fm) + CNT_W'(1);
            rsp_insns <= nxt_insns;
        end else begin
            rsp_hit   <= 1'b0;
            rsp_len   <= '0;
            rsp_insns <= '0;
        end
    end

    // ---------------- recency ----------------
    logic             lk_touch;
    logic [WAY_W-1:0] touch_way;
    logic [SETS-1:0]  touch_en;

    assign lk_touch  = lk_valid && found && !commit_valid;
    assign touch_way = commit_valid ? target : fw;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [WAYS-1:0] vb;
        logic            dup;
        logic            misplaced;

        assign touch_en[s] = commit_valid ? (cs == SET_W'(s))
                                          : (lk_touch && (fs == SET_W'(s)));

        always_comb begin
            dup       = 1'b0;
            misplaced = 1'b0;
            for (int a = 0; a < WAYS; a++) begin
                vb[a] = lines[s][a].valid;
                if (lines[s][a].valid && (set_of(lines[s][a].tag) != SET_W'(s)))
                    misplaced = 1'b1;
                for (int b = a + 1; b < WAYS; b++) begin
                    if (lines[s][a].valid && lines[s][b].valid &&
                        (lines[s][a].tag == lines[s][b].tag))
                        dup = 1'b1;
                end
            end
        end

        xbc_lru u_lru (
            .clk        (clk),
            .rst        (rst),
            .touch_en   (touch_en[s]),
            .touch_way  (touch_way),
            .valid_ways (vb),
            .victim     (vict[s])
        );

        a_r7_unique_tag: assert property (@(posedge clk) disable iff (rst) !dup);
        a_r4_home_set:   assert property (@(posedge clk) disable iff (rst) !misplaced);
    end

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(lk_valid) |-> (!rsp_hit && (rsp_len == '0)));

    a_r5_len_range: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> ((rsp_len != '0) && (rsp_len <= CNT_W'(SLOTS))));

    a_r1_miss_means_empty: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_insns == '0));

endmodule

// File: rtl/xblk_cache.sv
module xblk_cache
    import xbc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      fill_valid,
    output logic                      fill_ready,
    input  logic [IP_W-1:0]           fill_ip,
    input  logic [INSN_W-1:0]         fill_insn,
    input  logic [1:0]                fill_kind,
    input  logic                      lk_valid,
    input  logic [IP_W-1:0]           lk_ip,
    output logic                      lk_hit,
    output logic [CNT_W-1:0]          lk_len,
    output logic [SLOTS*INSN_W-1:0]   lk_insns
);

    kind_e             kind;
    logic              commit_valid;
    blk_t              commit_blk;
    ip_t               commit_tag;
    insn_t [SLOTS-1:0] rsp_insns;

    assign kind = kind_e'(fill_kind);

    xbc_builder u_builder (
        .clk          (clk),
        .rst          (rst),
        .fill_valid   (fill_valid),
        .fill_ip      (fill_ip),
        .fill_insn    (fill_insn),
        .fill_kind    (kind),
        .fill_ready   (fill_ready),
        .commit_valid (commit_valid),
        .commit_blk   (commit_blk),
        .commit_tag   (commit_tag)
    );

    xbc_store u_store (
        .clk          (clk),
        .rst          (rst),
        .commit_valid (commit_valid),
        .commit_blk   (commit_blk),
        .commit_tag   (commit_tag),
        .lk_valid     (lk_valid),
        .lk_ip        (lk_ip),
        .rsp_hit      (lk_hit),
        .rsp_len      (lk_len),
        .rsp_insns    (rsp_insns)
    );

    assign lk_insns = rsp_insns;

endmodule

// File: tb/sim_xblk_cache.sv
module sim_xblk_cache;
    import xbc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fill_valid = 1'b0;
    logic fill_ready;
    logic [31:0] fill_ip = '0;
    logic [31:0] fill_insn = '0;
    logic [1:0]  fill_kind = '0;
    logic lk_valid = 1'b0;
    logic [31:0] lk_ip = '0;
    logic lk_hit;
    logic [CNT_W-1:0] lk_len;
    logic [SLOTS*INSN_W-1:0] lk_insns;

    xblk_cache u0 (
        .clk(clk), .rst(rst),
        .fill_valid(fill_valid), .fill_ready(fill_ready),
        .fill_ip(fill_ip), .fill_insn(fill_insn), .fill_kind(fill_kind),
        .lk_valid(lk_valid), .lk_ip(lk_ip),
        .lk_hit(lk_hit), .lk_len(lk_len), .lk_insns(lk_insns)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur = "R5";

    // ---------------- behavioural model ----------------
    logic [31:0] q_ip[$];
    logic [31:0] q_in[$];
    bit          m_pend = 0;
    logic [31:0] p_ip[SLOTS];
    logic [31:0] p_in[SLOTS];
    int          p_cnt = 0;
    bit          mv[SETS][WAYS];
    logic [31:0] mt[SETS][WAYS];
    int          mc[SETS][WAYS];
    logic [31:0] mi[SETS][WAYS][SLOTS];
    logic [31:0] mn[SETS][WAYS][SLOTS];
    int          rec[SETS][$];
    bit          e_hit = 0;
    int          e_len = 0;
    logic [SLOTS*INSN_W-1:0] e_vec = '0;
    bit          last_acc = 0;

    function automatic logic [31:0] insn_of(logic [31:0] ip);
        return ip ^ 32'h5A00_00C3;
    endfunction

    function automatic int set_idx(logic [31:0] ip);
        return int'((ip >> IDX_LSB) % SETS);
    endfunction

    task automatic touch(int s, int w);
        foreach (rec[s][i]) begin
            if (rec[s][i] == w) begin
                rec[s].delete(i);
                break;
            end
        end
        rec[s].push_front(w);
    endtask

    task automatic model_edge();
        bit f = 0;
        int fs = 0, fw = 0, fm = 0;
        bit npend = 0;
        e_hit = 0; e_len = 0; e_vec = '0;
        if (lk_valid) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    for (int k = mc[s][w] - 1; k >= 0; k--)
                        if (!f && mv[s][w] && mi[s][w][k] == lk_ip) begin
                            f = 1; fs = s; fw = w; fm = k;
                        end
        end
        if (f) begin
            e_hit = 1;
            e_len = fm + 1;
            for (int j = 0; j <= fm; j++) e_vec[j*INSN_W +: INSN_W] = mn[fs][fw][fm-j];
        end
        if (m_pend) begin
            int cs = set_idx(p_ip[0]);
            int tw = -1;
            bit wr = 1;
            for (int w = 0; w < WAYS; w++)
                if (tw < 0 && mv[cs][w] && mt[cs][w] == p_ip[0]) tw = w;
            if (tw >= 0) begin
                wr = (p_cnt > mc[cs][tw]);
            end else begin
                for (int w = 0; w < WAYS; w++)
                    if (tw < 0 && !mv[cs][w]) tw = w;
                if (tw < 0) tw = rec[cs][$];
            end
            if (wr) begin
                mv[cs][tw] = 1; mt[cs][tw] = p_ip[0]; mc[cs][tw] = p_cnt;
                for (int k = 0; k < SLOTS; k++) begin
                    mi[cs][tw][k] = p_ip[k]; mn[cs][tw][k] = p_in[k];
                end
            end
            touch(cs, tw);
        end else if (f) begin
            touch(fs, fw);
        end
        last_acc = fill_valid && !m_pend;
        if (last_acc) begin
            q_ip.push_back(fill_ip);
            q_in.push_back(fill_insn);
            if (q_ip.size() > SLOTS) begin
                void'(q_ip.pop_front());
                void'(q_in.pop_front());
            end
            if (fill_kind >= 2) begin
                p_cnt = q_ip.size();
                for (int k = 0; k < SLOTS; k++) begin
                    p_ip[k] = (k < p_cnt) ? q_ip[p_cnt-1-k] : '0;
                    p_in[k] = (k < p_cnt) ? q_in[p_cnt-1-k] : '0;
                end
                q_ip.delete();
                q_in.delete();
                npend = 1;
            end
        end
        m_pend = npend;
    endtask

    task automatic chk(bit ok, string req, string what,
                       logic [SLOTS*INSN_W-1:0] act, logic [SLOTS*INSN_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        chk(fill_ready == !m_pend, cur, "fill_ready", 256'(fill_ready), 256'(!m_pend));
        chk(lk_hit == e_hit, cur, "lk_hit", 256'(lk_hit), 256'(e_hit));
        chk(int'(lk_len) == e_len, cur, "lk_len", 256'(lk_len), 256'(e_len));
        chk(lk_insns == e_vec, cur, "lk_insns", lk_insns, e_vec);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic fill_one(logic [31:0] ip, logic [1:0] kind);
        fill_valid = 1; fill_ip = ip; fill_insn = insn_of(ip); fill_kind = kind;
        do step(); while (!last_acc);
        fill_valid = 0;
    endtask

    task automatic fill_run(logic [31:0] start, int n, logic [1:0] endk);
        for (int i = 0; i < n; i++)
            fill_one(start + 32'(4*i), (i == n-1) ? endk : 2'd0);
        idle(2);
    endtask

    task automatic look(logic [31:0] ip);
        lk_valid = 1; lk_ip = ip;
        step();
        lk_valid = 0;
    endtask

    task automatic expect_look(logic [31:0] ip, bit hit, int len, string req);
        look(ip);
        chk(lk_hit == hit, req, $sformatf("hit @%0h", ip), 256'(lk_hit), 256'(hit));
        chk(int'(lk_len) == len, req, $sformatf("len @%0h", ip), 256'(lk_len), 256'(len));
        if (hit)
            chk(lk_insns[INSN_W-1:0] == insn_of(ip), req, "first insn",
                256'(lk_insns[INSN_W-1:0]), 256'(insn_of(ip)));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                mv[s][w] = 0; mt[s][w] = '0; mc[s][w] = 0;
            end
            for (int w = 0; w < WAYS; w++) rec[s].push_back(w);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        cur = "R1";
        #1;
        chk(fill_ready == 1'b1, "R1", "ready after reset", 256'(fill_ready), 256'(1));
        chk(lk_hit == 1'b0 && lk_len == '0, "R1", "quiet after reset", 256'(lk_len), 256'(0));
        expect_look(32'h100, 0, 0, "R1");

        // R4 R5 R6: simple conditional block, interior entries
        cur = "R6";
        fill_run(32'h100, 4, 2'd2);
        expect_look(32'h100, 1, 4, "R5");
        chk(lk_insns[3*INSN_W +: INSN_W] == insn_of(32'h10C), "R4", "exit at last position",
            256'(lk_insns[3*INSN_W +: INSN_W]), 256'(insn_of(32'h10C)));
        expect_look(32'h108, 1, 2, "R6");
        expect_look(32'h10C, 1, 1, "R6");
        expect_look(32'h110, 0, 0, "R6");

        // R10: idle cycle
        cur = "R10";
        step();
        chk(lk_hit == 0 && lk_len == 0, "R10", "idle response", 256'(lk_len), 256'(0));

        // R2: jump absorbed, indirect closes
        cur = "R2";
        fill_one(32'h200, 2'd0);
        fill_one(32'h204, 2'd1);
        fill_one(32'h300, 2'd0);
        fill_one(32'h304, 2'd3);
        idle(2);
        expect_look(32'h204, 1, 3, "R2");
        chk(lk_insns[2*INSN_W +: INSN_W] == insn_of(32'h304), "R2", "jump target run",
            256'(lk_insns[2*INSN_W +: INSN_W]), 256'(insn_of(32'h304)));
        expect_look(32'h200, 1, 4, "R2");

        // R7: extension at the head, then shorter refill leaves it alone
        cur = "R7";
        fill_run(32'h0F8, 6, 2'd2);
        expect_look(32'h0F8, 1, 6, "R7");
        fill_run(32'h108, 2, 2'd2);
        expect_look(32'h0F8, 1, 6, "R7");
        expect_look(32'h108, 1, 2, "R7");

        // R8: overlong run keeps only the last SLOTS instructions
        cur = "R8";
        fill_run(32'h400, 10, 2'd2);
        expect_look(32'h400, 0, 0, "R8");
        expect_look(32'h404, 0, 0, "R8");
        expect_look(32'h408, 1, 8, "R8");

        // R3: one-cycle bubble, visibility timing
        cur = "R3";
        fill_one(32'h2000, 2'd2);
        chk(fill_ready == 1'b0, "R3", "bubble", 256'(fill_ready), 256'(0));
        expect_look(32'h2000, 0, 0, "R3");
        chk(fill_ready == 1'b1, "R3", "ready returns", 256'(fill_ready), 256'(1));
        expect_look(32'h2000, 1, 1, "R3");

        // R9: replacement in set 0
        cur = "R9";
        fill_run(32'h1000, 1, 2'd2);
        fill_run(32'h1010, 1, 2'd2);
        fill_run(32'h1020, 1, 2'd2);
        fill_run(32'h1030, 1, 2'd2);
        look(32'h1000);
        fill_run(32'h1040, 1, 2'd2);
        expect_look(32'h1010, 0, 0, "R9");
        expect_look(32'h1000, 1, 1, "R9");
        expect_look(32'h1040, 1, 1, "R9");
        // lookup hit in a commit cycle leaves recency untouched
        fill_one(32'h1050, 2'd2);
        look(32'h1020);
        idle(1);
        fill_run(32'h1060, 1, 2'd2);
        fill_run(32'h1070, 1, 2'd3);
        look(32'h1020);
        look(32'h1030);

        // R11: same pointer recorded in two entries
        cur = "R11";
        fill_one(32'h3000, 2'd0);
        fill_one(32'h3004, 2'd1);
        fill_one(32'h3100, 2'd2);
        idle(2);
        fill_run(32'h3004, 2, 2'd2);
        expect_look(32'h3004, 1, 2, "R11");
        chk(lk_insns[INSN_W +: INSN_W] == insn_of(32'h3100), "R11", "lowest set wins",
            256'(lk_insns[INSN_W +: INSN_W]), 256'(insn_of(32'h3100)));

        cur = "R5";
        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule